// File: doc/BRIEF.md
# Address-Range Bus Watchpoint Unit

This block watches the transaction stream that a memory arbiter grants to its clients and flags accesses that fall inside programmed address windows. It has four independent comparators. Each comparator has an inclusive window from a low to a high address, a mask of allowed operation codes, and a mask of client numbers. A transaction that meets all three conditions is a hit for that comparator. A hit sets a sticky status bit. Each status bit can raise the single interrupt line through its own enable bit.

Each comparator keeps a record of the access that first hit it: the address, the operation code, the client number and the transfer size. While that record is held, later hits only add their client to an accumulated client set. Software reads the record through a small register port. It then releases the comparator and separately clears the status bit. A summary register names the lowest-numbered pending comparator, so a handler services comparators in index order. The block only observes traffic. It never stalls or blocks an access.

Top module: `wp_watch`

## Requirements
- R1: Comparator u hits in a cycle when `snp_valid` is 1, first[u] <= `snp_addr` <= last[u] (unsigned, both ends inclusive), bit `snp_op` of its operation mask is 1 (op code 0 = read, 1 = write), and bit `snp_client` of its client mask is 1. With no valid transaction there is no hit.
- R2: A hit sets status bit u at the next clock edge, whatever the enable bits are. The raw status reads at global offset 1, with bit u belonging to comparator u.
- R3: `irq` is 1 exactly when some status bit and the enable bit of the same index are both 1. Enable bit u (bits [3:0] of global offset 0, read/write) enables comparator u.
- R4: On a hit while the comparator is not holding a record, it records the address (unit offset 5) and an info word (unit offset 6: size in bits [7:0], client number in [15:8], op code in [23:16]). Later hits leave both fields unchanged until the comparator is released.
- R5: The client set (unit offset 7, bit c = client c) is loaded with only the hitting client's bit when a record is taken. Every later hit while the record is held ORs in that hit's client bit.
- R6: A write of any data to unit offset 4 releases the record. If a hit occurs in the same cycle, that hit is taken as a fresh record.
- R7: A write to global offset 3 clears every status bit whose data bit is 1. A hit in the same cycle on the same comparator leaves its bit set.
- R8: Global offset 2 reads the pending set (status AND enable) in bits [3:0]. Bits [10:8] hold 1 + the index of the lowest-numbered pending comparator, or 0 when none is pending.
- R9: Register map: global offsets 0..3 as above. Comparator u has its block at 16 + 8*u, with offsets 0 = window low, 1 = window high, 2 = op mask (bits [1:0]), 3 = client mask (bits [15:0]), 4/5/6/7 as above. Offsets 3 and 4 and unmapped addresses read 0. Writes to read-only offsets have no effect. All registers reset to 0.
- R10: A configuration write takes effect from the next cycle. A transaction in the same cycle as the write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| snp_valid | input | 1 | A granted transaction is present this cycle |
| snp_addr | input | 32 | Transaction address |
| snp_op | input | 1 | Operation code (0 read, 1 write) |
| snp_client | input | 4 | Requesting client number |
| snp_size | input | 8 | Transfer size |
| irq | output | 1 | Interrupt request |

## Verification
Directed transactions probe each window at its low and high edges and one address outside each edge. They also present a disallowed op code and a client outside the mask, which separates the inclusive window compare from each qualifier on its own. Repeated hits from different clients on a held comparator separate the frozen first-hit fields from the accumulating client set. Overlapping hits on two comparators check the lowest-index choice in the summary. Release and clear writes placed in the same cycle as a hit check the same-cycle priorities. A long random phase then mixes reconfiguration, releases, clears and dense traffic over a small address space, and a behavioural model checks `irq` and the read data on every clock.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // global register offsets
  localparam int GLB_ENABLE  = 0;
  localparam int GLB_RAW     = 1;
  localparam int GLB_SUMMARY = 2;
  localparam int GLB_CLEAR   = 3;
  localparam int UNIT_BASE   = 16;
  localparam int UNIT_STRIDE = 8;

  // per-comparator offsets
  localparam logic [2:0] U_LOW     = 3'd0;
  localparam logic [2:0] U_HIGH    = 3'd1;
  localparam logic [2:0] U_OPMASK  = 3'd2;
  localparam logic [2:0] U_CLIMASK = 3'd3;
  localparam logic [2:0] U_RELEASE = 3'd4;
  localparam logic [2:0] U_CAPADDR = 3'd5;
  localparam logic [2:0] U_CAPINFO = 3'd6;
  localparam logic [2:0] U_CAPCLI  = 3'd7;

  // bit positions inside the record info word and summary word
  localparam int INFO_SIZE_LSB   = 0;
  localparam int INFO_CLIENT_LSB = 8;
  localparam int INFO_OP_LSB     = 16;
  localparam int SUM_TAG_LSB     = 8;
endpackage

// File: rtl/wp_match.sv
module wp_match
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CLI_W   = 4,
  parameter int NUM_OPS = 2,
  parameter int OP_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [OP_W-1:0]   snp_op,
  input  logic [CLI_W-1:0]  snp_client,
  input  logic [2:0]        rd_sel,
  output logic              hit,
  output logic [ADDR_W-1:0] rd_cfg
);
  localparam int NCLI = 1 << CLI_W;

  logic [ADDR_W-1:0]  low_q, high_q;
  logic [NUM_OPS-1:0] opm_q;
  logic [NCLI-1:0]    clim_q;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic op_allowed(input logic [NUM_OPS-1:0] m,
                                      input logic [OP_W-1:0] op);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_OPS; k++)
      if (int'(op) == k) r = m[k];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
      opm_q  <= '0;
      clim_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        U_LOW:     low_q  <= cfg_wdata;
        U_HIGH:    high_q <= cfg_wdata;
        U_OPMASK:  opm_q  <= cfg_wdata[NUM_OPS-1:0];
        U_CLIMASK: clim_q <= cfg_wdata[NCLI-1:0];
        default: ;
      endcase
    end
  end

  assign hit = snp_valid && in_window(snp_addr, low_q, high_q)
               && op_allowed(opm_q, snp_op) && clim_q[snp_client];

  always_comb begin
    case (rd_sel)
      U_LOW:     rd_cfg = low_q;
      U_HIGH:    rd_cfg = high_q;
      U_OPMASK:  rd_cfg = ADDR_W'(opm_q);
      U_CLIMASK: rd_cfg = ADDR_W'(clim_q);
      default:   rd_cfg = '0;
    endcase
  end
endmodule

// File: rtl/wp_capture.sv
module wp_capture
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CLI_W  = 4,
  parameter int OP_W   = 1,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              release_i,
  input  logic              hit,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [OP_W-1:0]   snp_op,
  input  logic [CLI_W-1:0]  snp_client,
  input  logic [SIZE_W-1:0] snp_size,
  input  logic [2:0]        rd_sel,
  output logic              locked,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] rd_cap
);
  localparam int NCLI = 1 << CLI_W;

  logic              locked_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OP_W-1:0]   op_q;
  logic [CLI_W-1:0]  first_q;
  logic [SIZE_W-1:0] size_q;
  logic [NCLI-1:0]   cli_q;
  logic              held;
  logic [NCLI-1:0]   cli_bit;

  function automatic logic [ADDR_W-1:0] pack_info(input logic [SIZE_W-1:0] sz,
                                                  input logic [CLI_W-1:0] c,
                                                  input logic [OP_W-1:0] op);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[INFO_SIZE_LSB   +: SIZE_W] = sz;
    w[INFO_CLIENT_LSB +: CLI_W]  = c;
    w[INFO_OP_LSB     +: OP_W]   = op;
    return w;
  endfunction

  assign held    = locked_q && !release_i;
  assign cli_bit = NCLI'(1) << snp_client;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      addr_q   <= '0;
      op_q     <= '0;
      first_q  <= '0;
      size_q   <= '0;
      cli_q    <= '0;
    end else if (hit) begin
      locked_q <= 1'b1;
      if (!held) begin
        addr_q  <= snp_addr;
        op_q    <= snp_op;
        first_q <= snp_client;
        size_q  <= snp_size;
        cli_q   <= cli_bit;
      end else begin
        cli_q   <= cli_q | cli_bit;
      end
    end else begin
      locked_q <= held;
    end
  end

  assign locked   = locked_q;
  assign cap_addr = addr_q;

  always_comb begin
    case (rd_sel)
      U_CAPADDR: rd_cap = addr_q;
      U_CAPINFO: rd_cap = pack_info(size_q, first_q, op_q);
      U_CAPCLI:  rd_cap = ADDR_W'(cli_q);
      default:   rd_cap = '0;
    endcase
  end
endmodule

// File: rtl/wp_irq_ctrl.sv
module wp_irq_ctrl #(
  parameter int NUM_WP = 4,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_we,
  input  logic [NUM_WP-1:0] enable_wdata,
  input  logic [NUM_WP-1:0] clear_vec,
  input  logic [NUM_WP-1:0] hit_vec,
  output logic [NUM_WP-1:0] status,
  output logic [NUM_WP-1:0] enable,
  output logic [NUM_WP-1:0] pending,
  output logic [TAG_W-1:0]  first_tag,
  output logic              irq
);
  logic [NUM_WP-1:0] status_q, enable_q;

  function automatic logic [TAG_W-1:0] lowest_tag(input logic [NUM_WP-1:0] v);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int i = NUM_WP - 1; i >= 0; i--)
      if (v[i]) t = TAG_W'(i + 1);
    return t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clear_vec) | hit_vec;
      if (enable_we) enable_q <= enable_wdata;
    end
  end

  assign status    = status_q;
  assign enable    = enable_q;
  assign pending   = status_q & enable_q;
  assign first_tag = lowest_tag(pending);
  assign irq       = |pending;
endmodule

// File: rtl/wp_watch.sv
module wp_watch
  import wp_pkg::*;
#(
  parameter int NUM_WP  = 4,
  parameter int ADDR_W  = 32,
  parameter int CLI_W   = 4,
  parameter int NUM_OPS = 2,
  parameter int SIZE_W  = 8,
  localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int REG_AW = $clog2(UNIT_BASE + UNIT_STRIDE * NUM_WP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [OP_W-1:0]   snp_op,
  input  logic [CLI_W-1:0]  snp_client,
  input  logic [SIZE_W-1:0] snp_size,
  output logic              irq
);
  localparam int TAG_W = $clog2(NUM_WP + 1);

  // decode
  logic              in_glb;
  logic [REG_AW-1:0] uoff;
  logic [2:0]        usel;
  logic [NUM_WP-1:0] unit_sel;

  // named events for the checker
  logic [NUM_WP-1:0]        hit_vec;
  logic [NUM_WP-1:0]        lock_vec;
  logic [NUM_WP-1:0]        rel_vec;
  logic [NUM_WP-1:0]        clear_vec;
  logic [NUM_WP-1:0]        status_vec;
  logic [NUM_WP-1:0]        enable_vec;
  logic [NUM_WP-1:0]        pending_vec;
  logic [TAG_W-1:0]         first_tag;
  logic [NUM_WP*ADDR_W-1:0] cap_addr_flat;

  logic [ADDR_W-1:0] unit_rd [NUM_WP];
  logic [ADDR_W-1:0] summary;

  assign in_glb = reg_addr < REG_AW'(UNIT_BASE);
  assign uoff   = reg_addr - REG_AW'(UNIT_BASE);
  assign usel   = uoff[2:0];

  assign clear_vec = (reg_wr && in_glb && reg_addr == REG_AW'(GLB_CLEAR))
                     ? reg_wdata[NUM_WP-1:0] : '0;

  for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
    logic [ADDR_W-1:0] rd_cfg, rd_cap;

    assign unit_sel[u] = !in_glb && (uoff[REG_AW-1:3] == (REG_AW-3)'(u));
    assign rel_vec[u]  = reg_wr && unit_sel[u] && usel == U_RELEASE;

    wp_match #(
      .ADDR_W(ADDR_W), .CLI_W(CLI_W), .NUM_OPS(NUM_OPS), .OP_W(OP_W)
    ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (reg_wr && unit_sel[u]),
      .cfg_sel    (usel),
      .cfg_wdata  (reg_wdata),
      .snp_valid  (snp_valid),
      .snp_addr   (snp_addr),
      .snp_op     (snp_op),
      .snp_client (snp_client),
      .rd_sel     (usel),
      .hit        (hit_vec[u]),
      .rd_cfg     (rd_cfg)
    );

    wp_capture #(
      .ADDR_W(ADDR_W), .CLI_W(CLI_W), .OP_W(OP_W), .SIZE_W(SIZE_W)
    ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .release_i  (rel_vec[u]),
      .hit        (hit_vec[u]),
      .snp_addr   (snp_addr),
      .snp_op     (snp_op),
      .snp_client (snp_client),
      .snp_size   (snp_size),
      .rd_sel     (usel),
      .locked     (lock_vec[u]),
      .cap_addr   (cap_addr_flat[u*ADDR_W +: ADDR_W]),
      .rd_cap     (rd_cap)
    );

    assign unit_rd[u] = usel[2] ? rd_cap : rd_cfg;
  end

  wp_irq_ctrl #(
    .NUM_WP(NUM_WP), .TAG_W(TAG_W)
  ) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_we    (reg_wr && in_glb && reg_addr == REG_AW'(GLB_ENABLE)),
    .enable_wdata (reg_wdata[NUM_WP-1:0]),
    .clear_vec    (clear_vec),
    .hit_vec      (hit_vec),
    .status       (status_vec),
    .enable       (enable_vec),
    .pending      (pending_vec),
    .first_tag    (first_tag),
    .irq          (irq)
  );

  always_comb begin
    summary = '0;
    summary[NUM_WP-1:0] = pending_vec;
    summary[SUM_TAG_LSB +: TAG_W] = first_tag;
  end

  always_comb begin
    reg_rdata = '0;
    if (in_glb) begin
      if (reg_addr == REG_AW'(GLB_ENABLE))       reg_rdata = ADDR_W'(enable_vec);
      else if (reg_addr == REG_AW'(GLB_RAW))     reg_rdata = ADDR_W'(status_vec);
      else if (reg_addr == REG_AW'(GLB_SUMMARY)) reg_rdata = summary;
    end else begin
      for (int u = 0; u < NUM_WP; u++)
        if (unit_sel[u]) reg_rdata = unit_rd[u];
    end
  end
endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk #(
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     snp_valid,
  input logic                     irq,
  input logic [NUM_WP-1:0]        hit_vec,
  input logic [NUM_WP-1:0]        lock_vec,
  input logic [NUM_WP-1:0]        rel_vec,
  input logic [NUM_WP-1:0]        clear_vec,
  input logic [NUM_WP-1:0]        status_vec,
  input logic [NUM_WP-1:0]        enable_vec,
  input logic [NUM_WP*ADDR_W-1:0] cap_addr_flat
);
  // R1
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> snp_valid);

  // R3
  no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_vec == '0) |-> !irq);

  for (genvar u = 0; u < NUM_WP; u++) begin : g_u
    // R2
    hit_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[u] |=> status_vec[u]);

    // R4
    record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_vec[u] && !rel_vec[u]) |=>
        (lock_vec[u] && $stable(cap_addr_flat[u*ADDR_W +: ADDR_W])));

    // R4
    lock_rises_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_vec[u]) |-> $past(hit_vec[u]));

    // R6
    release_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vec[u] && !hit_vec[u]) |=> !lock_vec[u]);

    // R7
    clear_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_vec[u] && !hit_vec[u]) |=> !status_vec[u]);
  end
endmodule

bind wp_watch wp_watch_chk #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .snp_valid     (snp_valid),
  .irq           (irq),
  .hit_vec       (hit_vec),
  .lock_vec      (lock_vec),
  .rel_vec       (rel_vec),
  .clear_vec     (clear_vec),
  .status_vec    (status_vec),
  .enable_vec    (enable_vec),
  .cap_addr_flat (cap_addr_flat)
);

// File: tb/wp_watch_bench.sv
`timescale 1ns/1ps
module wp_watch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic [0:0]  snp_op = '0;
  logic [3:0]  snp_client = '0;
  logic [7:0]  snp_size = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wp_watch u_wp_watch (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .snp_op(snp_op), .snp_client(snp_client),
    .snp_size(snp_size), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_lo [4], m_hi [4], m_caddr [4], m_ccli [4];
  int m_opm [4], m_cmask [4], m_lock [4], m_cop [4], m_cfirst [4], m_csize [4];
  int m_en, m_stat;

  function automatic int lowest_plus1(int v);
    for (int i = 0; i < 4; i++) if (v & (1 << i)) return i + 1;
    return 0;
  endfunction

  function automatic logic [31:0] expect_rd(int a);
    int u, o;
    if (a < 16) begin
      case (a)
        0: return 32'(m_en);
        1: return 32'(m_stat);
        2: return 32'((m_stat & m_en) | (lowest_plus1(m_stat & m_en) << 8));
        default: return 0;
      endcase
    end
    u = (a - 16) / 8;
    o = (a - 16) % 8;
    if (u >= 4) return 0;
    case (o)
      0: return m_lo[u];
      1: return m_hi[u];
      2: return 32'(m_opm[u]);
      3: return 32'(m_cmask[u]);
      5: return m_caddr[u];
      6: return 32'((m_cop[u] << 16) | (m_cfirst[u] << 8) | m_csize[u]);
      7: return m_ccli[u];
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 4; u++) begin
      m_lo[u] = 0; m_hi[u] = 0; m_caddr[u] = 0; m_ccli[u] = 0;
      m_opm[u] = 0; m_cmask[u] = 0; m_lock[u] = 0;
      m_cop[u] = 0; m_cfirst[u] = 0; m_csize[u] = 0;
    end
    m_en = 0; m_stat = 0;
  endtask

  task automatic model_step();
    int hits, clr, a, u, o;
    bit rel;
    hits = 0;
    for (int k = 0; k < 4; k++)
      if (snp_valid && snp_addr >= m_lo[k] && snp_addr <= m_hi[k] &&
          ((m_opm[k] >> snp_op) & 1) && ((m_cmask[k] >> snp_client) & 1))
        hits |= (1 << k);
    a = reg_addr;
    u = (a >= 16) ? (a - 16) / 8 : -1;
    o = (a >= 16) ? (a - 16) % 8 : -1;
    clr = (reg_wr && a == 3) ? int'(reg_wdata[3:0]) : 0;
    for (int k = 0; k < 4; k++) begin
      rel = reg_wr && u == k && o == 4;
      if (rel) m_lock[k] = 0;
      if (hits & (1 << k)) begin
        if (!m_lock[k]) begin
          m_caddr[k] = snp_addr; m_cop[k] = snp_op;
          m_cfirst[k] = snp_client; m_csize[k] = snp_size;
          m_ccli[k] = 32'(1) << snp_client;
          m_lock[k] = 1;
        end else m_ccli[k] |= 32'(1) << snp_client;
      end
    end
    m_stat = (m_stat & ~clr) | hits;
    if (reg_wr) begin
      if (a == 0) m_en = int'(reg_wdata[3:0]);
      if (u >= 0 && u < 4) case (o)
        0: m_lo[u] = reg_wdata;
        1: m_hi[u] = reg_wdata;
        2: m_opm[u] = int'(reg_wdata[1:0]);
        3: m_cmask[u] = int'(reg_wdata[15:0]);
        default: ;
      endcase
    end
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge, irq compared every cycle (R3)
  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    chk(irq === (((m_stat & m_en) != 0) ? 1'b1 : 1'b0), "R3 irq",
        32'(irq), 32'((m_stat & m_en) != 0));
  endtask

  task automatic idle();
    reg_wr = 0; snp_valid = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = 6'(a); reg_wdata = d; tick(); idle();
  endtask

  task automatic snoop(logic [31:0] a, int op, int c, int sz);
    snp_valid = 1; snp_addr = a; snp_op = 1'(op); snp_client = 4'(c);
    snp_size = 8'(sz); tick(); idle();
  endtask

  task automatic rd(int a, string req);
    reg_addr = 6'(a); #1;
    chk(reg_rdata === expect_rd(a), req, reg_rdata, expect_rd(a));
  endtask

  task automatic rd_unit(int u, string req);
    for (int o = 0; o < 8; o++) rd(16 + 8 * u + o, req);
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int a;
    model_reset();
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int r = 0; r < 48; r++) rd(r, "R9 reset");
    chk(irq === 1'b0, "R9 reset irq", 32'(irq), 0);
    rst_n = 1;
    @(negedge clk);

    // comparator 0: window 0x1000..0x1FFF, writes only, clients 3 and 5
    wr(16, 32'h1000); wr(17, 32'h1FFF); wr(18, 32'h2); wr(19, 32'h0028);
    rd_unit(0, "R9 config readback");
    snoop(32'h1000, 0, 3, 4);  rd(1, "R1 op masked");     // read: no hit
    snoop(32'h0FFF, 1, 3, 4);  rd(1, "R1 below low");
    snoop(32'h1000, 1, 4, 4);  rd(1, "R1 client masked");
    snoop(32'h1000, 1, 3, 4);  rd(1, "R2 low edge hit");
    chk(irq === 1'b0, "R3 disabled irq", 32'(irq), 0);
    rd_unit(0, "R4 first record");
    wr(0, 32'h1);              rd(2, "R8 summary");
    snoop(32'h1FFF, 1, 5, 9);  rd_unit(0, "R5 accumulate");   // high edge
    snoop(32'h2000, 1, 5, 9);  rd_unit(0, "R1 above high");
    snoop(32'h1800, 0, 3, 2);  rd_unit(0, "R4 frozen");

    // R10: configuration write and snoop in the same cycle
    reg_wr = 1; reg_addr = 6'(16); reg_wdata = 32'h1900;
    snp_valid = 1; snp_addr = 32'h1100; snp_op = 1; snp_client = 3; snp_size = 1;
    tick(); idle();
    rd(1, "R10 old config"); rd_unit(0, "R10 record");
    snoop(32'h1100, 1, 3, 1);  rd(1, "R10 new config");

    // comparators 1 and 2 overlap; lowest pending reported first (R8)
    wr(24, 32'h40); wr(25, 32'h7F); wr(26, 32'h3); wr(27, 32'hFFFF);
    wr(32, 32'h60); wr(33, 32'h90); wr(34, 32'h1); wr(35, 32'hFFFF);
    wr(0, 32'h6);
    snoop(32'h70, 0, 7, 3);    rd(2, "R8 two pending"); rd(1, "R2 raw");
    wr(3, 32'h2);              rd(2, "R8 after clear"); rd(1, "R7 clear");
    wr(0, 32'h0);              rd(2, "R8 none enabled");
    chk(irq === 1'b0, "R3 mask off", 32'(irq), 0);
    wr(0, 32'hF);

    // R7: clear with a hit on the same comparator in the same cycle
    reg_wr = 1; reg_addr = 6'(3); reg_wdata = 32'h4;
    snp_valid = 1; snp_addr = 32'h88; snp_op = 0; snp_client = 1; snp_size = 6;
    tick(); idle();
    rd(1, "R7 hit wins");

    // R6: release, then release with simultaneous hit
    wr(16 + 8 * 2 + 4, 32'h0); rd_unit(2, "R6 released");
    snoop(32'h61, 0, 9, 7);    rd_unit(2, "R6 fresh record");
    reg_wr = 1; reg_addr = 6'(16 + 8 * 2 + 4); reg_wdata = '0;
    snp_valid = 1; snp_addr = 32'h62; snp_op = 0; snp_client = 11; snp_size = 8;
    tick(); idle();
    rd_unit(2, "R6 same-cycle capture");
    snoop(32'h63, 0, 12, 2);   rd_unit(2, "R5 after recapture");
    rd(50, "R9 unmapped");

    // random phase: model compared every clock
    for (int n = 0; n < 4000; n++) begin
      a = $urandom_range(0, 63);
      d = $urandom_range(0, 1) ? 32'($urandom_range(0, 255)) : 32'($urandom);
      reg_wr = ($urandom_range(0, 4) == 0);
      reg_addr = 6'(a); reg_wdata = d;
      snp_valid = ($urandom_range(0, 2) != 0);
      snp_addr = 32'($urandom_range(0, 255));
      snp_op = 1'($urandom_range(0, 1));
      snp_client = 4'($urandom_range(0, 15));
      snp_size = 8'($urandom_range(0, 255));
      tick();
      rd(a, "R1 R4 R5 R8 random read");
      idle();
    end
    for (int u = 0; u < 4; u++) rd_unit(u, "R4 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule